// File: doc/BRIEF.md
# Programmable-Length Pipeline Delay Line

This block delays a byte-wide data stream by a number of clock cycles that is chosen at run time, from 1 up to 16. Every rising clock edge pushes the input word into a fixed chain of fifteen stage registers. A selector passes either the raw input word or the contents of one chain stage to a final output register. The data output is always driven from that output register.

The latency is set by a 4-bit length code. The code is captured into its own register, so a new value acts one edge after it is sampled. The chain shifts on every edge whatever the code is. Changing the code only moves the selection point and never alters the words held in the chain. Shortening the delay therefore makes the output skip ahead to newer words. Lengthening it makes the output present older words again, because those words are still in the chain.

Top module: `pdl_delay_line`

## Requirements
- R1: With a registered length code of 0, data_out after rising edge t equals the data_in word sampled at edge t. This is a latency of one cycle, through the output register alone.
- R2: The length code is an unsigned binary value n. A registered code n from 1 to 15 loads chain stage n into the output register. A code held steady delays the data by n+1 cycles, which is 16 cycles at code 15.
- R3: The length code sampled at edge k selects the word that is loaded into the output register at edge k+1. A new code has no effect on the load at the edge where it is sampled.
- R4: The fifteen-stage chain shifts on every non-reset edge, whatever the code. A code change leaves every chain word unchanged. After the code is lengthened, the output therefore presents older words that are still in the chain.
- R5: A low rst_n at a rising edge clears all chain stages, the output register and the code register. data_out is 0 after that edge. Once reset is released, the delay stays at one cycle until a new code is captured, and every chain stage reads 0 until fresh data has been shifted into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 8 | Input data word |
| len_code | input | 4 | Length code; delay is code plus one cycles |
| data_out | output | 8 | Delayed data word, driven from the output register |

## Verification
The bench builds the block with its default parameters: an 8-bit data word and a 4-bit code, which gives a fifteen-stage chain. With these values all sixteen latencies can be reached, including the longest one, where data leaves the last chain stage. A reference history, indexed by the code captured one edge earlier, predicts every output word. This exposes both the one-edge lag of the code register and the words that reappear when a short delay is switched back to a long one.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
    // Default geometry of the delay line
    parameter int unsigned PDL_DATA_W = 8;
    parameter int unsigned PDL_CODE_W = 4;

    // Number of chain stages that a code of the given width can address
    function automatic int unsigned pdl_depth(input int unsigned code_w);
        return (1 << code_w) - 1;
    endfunction
endpackage

// File: rtl/pdl_tap_chain.sv
module pdl_tap_chain
    import pdl_pkg::*;
#(
    parameter int unsigned DATA_W = PDL_DATA_W,
    parameter int unsigned DEPTH  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             din,
    output logic [DEPTH:1][DATA_W-1:0]    taps
);
    logic [DEPTH:1][DATA_W-1:0] stage_d;
    logic [DEPTH:1][DATA_W-1:0] stage_q;

    // First stage takes the input, every other stage takes its predecessor
    assign stage_d[1] = din;
    for (genvar g = 2; g <= DEPTH; g++) begin : g_shift
        assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign taps = stage_q;
endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select
    import pdl_pkg::*;
#(
    parameter int unsigned DATA_W = PDL_DATA_W,
    parameter int unsigned CODE_W = PDL_CODE_W,
    localparam int unsigned DEPTH = (1 << CODE_W) - 1
) (
    input  logic [DATA_W-1:0]          din,
    input  logic [DEPTH:1][DATA_W-1:0] taps,
    input  logic [CODE_W-1:0]          code,
    output logic [DATA_W-1:0]          sel
);
    // Candidate 0 is the raw input; candidate n is chain stage n
    logic [DEPTH:0][DATA_W-1:0] cand;

    assign cand[0]       = din;
    assign cand[DEPTH:1] = taps;

    always_comb begin
        sel = cand[code];
    end
endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line
    import pdl_pkg::*;
#(
    parameter int unsigned DATA_W = PDL_DATA_W,
    parameter int unsigned CODE_W = PDL_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CODE_W-1:0] len_code,
    output logic [DATA_W-1:0] data_out
);
    localparam int unsigned DEPTH = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] dout;
    } state_t;

    state_t                     st_d;
    state_t                     st_q;
    logic [DEPTH:1][DATA_W-1:0] taps;
    logic [DATA_W-1:0]          picked;

    pdl_tap_chain #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) chain_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (data_in),
        .taps (taps)
    );

    // Selection uses the registered code, not the live input
    pdl_tap_select #(
        .DATA_W(DATA_W),
        .CODE_W(CODE_W)
    ) select_i (
        .din (data_in),
        .taps(taps),
        .code(st_q.code),
        .sel (picked)
    );

    always_comb begin
        st_d      = st_q;
        st_d.code = len_code;
        st_d.dout = picked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.dout;
endmodule

// File: rtl/pdl_delay_line_chk.sv
module pdl_delay_line_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_in,
    input logic [CODE_W-1:0] len_code,
    input logic [DATA_W-1:0] data_out
);
    // Edges since reset release, saturating
    logic [4:0] run_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
        if (!rst_n) begin
            run_q <= '0;
        end else if (run_q != 5'd31) begin
            run_q <= run_q + 5'd1;
        end
    end

    // R1
    code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q >= 5'd20 && len_code == CODE_W'(0)) |=> ##1 (data_out == $past(data_in)));

    // R2
    code_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q >= 5'd20 && len_code == CODE_W'(3)) |=> ##1 (data_out == $past(data_in, 4)));

    // R2
    code_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q >= 5'd20 && len_code == CODE_W'(7)) |=> ##1 (data_out == $past(data_in, 8)));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        (seen_q && !$past(rst_n)) |-> (data_out == '0));
endmodule

bind pdl_delay_line pdl_delay_line_chk #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (data_in),
    .len_code(len_code),
    .data_out(data_out)
);

// File: tb/pdl_delay_line_tb.sv
module pdl_delay_line_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = '0;
    logic [3:0] len_code = '0;
    logic [7:0] data_out;

    int checks = 0;
    int errors = 0;
    int cyc = 20;
    bit done = 0;

    logic [7:0] hist [0:8191];
    logic [3:0] creg [0:8191];

    // Stimulus vectors: {code, data}
    localparam logic [11:0] VEC [0:31] = '{
        12'h011, 12'h022, 12'h033, 12'h144, 12'h155, 12'h166, 12'h277, 12'h288,
        12'h299, 12'h2AA, 12'h5BB, 12'h5CC, 12'h5DD, 12'h5EE, 12'h5FF, 12'h501,
        12'h102, 12'h103, 12'h404, 12'h405, 12'h406, 12'h007, 12'h708, 12'h709,
        12'h70A, 12'h70B, 12'h70C, 12'h70D, 12'h70E, 12'h70F, 12'h310, 12'h311
    };

    pdl_delay_line dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_in),
        .len_code(len_code),
        .data_out(data_out)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic step(input logic r, input logic [7:0] d, input logic [3:0] c, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        rst_n = r; data_in = d; len_code = c;
        @(posedge clk);
        #1;
        if (!r) begin
            hist[cyc] = '0; creg[cyc] = '0; exp = '0;
        end else begin
            hist[cyc] = d; creg[cyc] = c;
            exp = hist[cyc - int'(creg[cyc-1])];
        end
        cyc++;
        checks++;
        if (data_out !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d data_out=%h expected=%h", tag, cyc, data_out, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8192; i++) begin hist[i] = '0; creg[i] = '0; end
        // R5: reset state, chain and output cleared
        for (int i = 0; i < 16; i++) step(1'b0, 8'hA5, 4'hF, "R5");
        // R5: long code right after release reads zeros until refill
        for (int i = 0; i < 20; i++) step(1'b1, 8'(i + 8'h40), 4'hF, "R5");
        // Vector table walk: R1, R2, R3 code changes mid-stream
        for (int i = 0; i < 32; i++) step(1'b1, VEC[i][7:0], VEC[i][11:8], "R3");
        // R1/R2: every code held steady
        for (int c = 0; c < 16; c++)
            for (int k = 0; k < 20; k++)
                step(1'b1, 8'(c * 17 + k * 3 + 1), 4'(c), (c == 0) ? "R1" : "R2");
        // R4: fill at code 15, shorten to 0, lengthen back: older words reappear
        for (int k = 0; k < 18; k++) step(1'b1, 8'(k + 8'h80), 4'hF, "R4");
        for (int k = 0; k < 3; k++)  step(1'b1, 8'(k + 8'hC0), 4'h0, "R4");
        for (int k = 0; k < 18; k++) step(1'b1, 8'(k + 8'hD0), 4'hF, "R4");
        // R3: single-cycle code pulse acts one edge late
        step(1'b1, 8'h01, 4'h9, "R3");
        step(1'b1, 8'h02, 4'h0, "R3");
        step(1'b1, 8'h03, 4'h0, "R3");
        // R5: mid-stream reset then resume
        for (int i = 0; i < 16; i++) step(1'b0, 8'h5A, 4'h6, "R5");
        for (int i = 0; i < 10; i++) step(1'b1, 8'(i + 8'h20), 4'h6, "R5");
        finish_run();
    end
endmodule